// File: doc/BRIEF.md
# Priority-Override Bus Request Arbiter

This block decides, cycle by cycle, whether a symmetric bus agent may start a new transaction on a bus it shares with one high-priority agent. The symmetric agent reports a pending request, and it also flags whether that request belongs to a locked sequence. The block then drives the agent's active-low bus request line. It also raises a grant-to-issue signal whenever the new transaction may go out. Only two agents take part in arbitration.

The priority agent is modelled inside the block. It keeps a count of its outstanding requests and drives an active-low priority line from that count. It holds the line low until all of its queued work has finished, and it releases the bus by driving the line high again. The symmetric agent samples the priority line on the rising clock edge. While the sampled priority is active, new requests are held back. The exception is a locked sequence that is already under way: it may keep issuing until its last transaction goes out.

Top module: `bus_req_arbiter`

## Requirements
- R1: While reset is asserted, `breq_n` and `prio_n` are 1, `issue`, `lock_held` and `prio_seen` are 0, and the outstanding counter is cleared.
- R2: `breq_n` equals the inverse of `req_pend` from the previous cycle (0 means the bus is requested).
- R3: When `prio_seen` is 0, `issue` equals `req_pend` in the same cycle.
- R4: When `prio_seen` is 1 and `lock_held` is 0, `issue` is 0 whatever the request inputs are.
- R5: An issued transaction with `req_lock`=1 and `req_lock_last`=0 sets `lock_held` on the next edge. An issued transaction with `req_lock`=1 and `req_lock_last`=1 clears it. While `lock_held` is 1, `issue` equals `req_pend` even under priority.
- R6: The outstanding counter rises by one on `pa_new` alone and falls by one on `pa_done` alone. It is unchanged when both are high. A `pa_done` at zero is ignored, and so is a `pa_new` when the counter is all ones.
- R7: `prio_n` goes low at the same edge where the counter becomes non-zero. It stays low while the counter is non-zero and returns high one cycle after the counter reaches zero.
- R8: `prio_seen` equals the inverse of `prio_n` from the previous cycle. A request presented in the first cycle that `prio_n` is low is therefore still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | 1 | Symmetric agent has a new transaction to start |
| req_lock | input | 1 | Pending transaction is part of a locked sequence |
| req_lock_last | input | 1 | Pending locked transaction is the last of its sequence |
| pa_new | input | 1 | Priority agent queues one request |
| pa_done | input | 1 | Priority agent completes one request |
| breq_n | output | 1 | Symmetric agent bus request, active low |
| prio_n | output | 1 | Priority line from the priority agent model, active low |
| issue | output | 1 | A new transaction may start this cycle |
| lock_held | output | 1 | A locked sequence is in progress |
| prio_seen | output | 1 | Priority sampled active at the last edge |

## Verification
The bench builds the block with a 2-bit outstanding counter. With that width, bursts of `pa_new` drive the counter to its all-ones limit, so the saturation rule of R6 is exercised. Frequent `pa_done` pulses also return the counter to zero often, which exercises the one-cycle release tail of R7. Directed phases cover a locked sequence that starts before priority and runs through it, and also a locked start attempted while priority is already held. A long randomized phase then mixes all inputs, with comparisons made against a behavioural model on every cycle.

// File: rtl/bus_req_arbiter.sv
module bus_req_arbiter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pend,
  input  logic req_lock,
  input  logic req_lock_last,
  input  logic pa_new,
  input  logic pa_done,
  output logic breq_n,
  output logic prio_n,
  output logic issue,
  output logic lock_held,
  output logic prio_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic prio_act, prio_s, lock_q, breq_q;

  wire inc = pa_new & ~pa_done & (cnt != CNT_MAX);
  wire dec = pa_done & ~pa_new & (cnt != '0);

  assign cnt_nxt = inc ? cnt + CNT_ONE : (dec ? cnt - CNT_ONE : cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      prio_act <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      prio_act <= (cnt_nxt != '0) | (cnt != '0);
    end
  end

  assign issue = rst_n & req_pend & (~prio_s | lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_s <= 1'b0;
      lock_q <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      prio_s <= prio_act;
      breq_q <= req_pend;
      if (issue && req_lock)
        lock_q <= ~req_lock_last;
    end
  end

  assign breq_n    = ~breq_q;
  assign prio_n    = ~prio_act;
  assign lock_held = lock_q;
  assign prio_seen = prio_s;
endmodule

// File: rtl/bus_req_arbiter_chk.sv
module bus_req_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_pend,
  input logic req_lock,
  input logic req_lock_last,
  input logic pa_new,
  input logic pa_done,
  input logic breq_n,
  input logic prio_n,
  input logic issue,
  input logic lock_held,
  input logic prio_seen
);
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_seen |-> issue == req_pend); // R3
  AST_PRIO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    prio_seen && !lock_held |-> !issue); // R4
  AST_BREQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> breq_n == !$past(req_pend)); // R2
  AST_PRIO_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prio_seen == !$past(prio_n)); // R8
  AST_LOCK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && req_lock && req_lock_last |=> !lock_held); // R5
  AST_LOCK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && req_lock && !req_lock_last |=> lock_held); // R5
  AST_NEW_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    pa_new && !pa_done |=> !prio_n); // R7
  always_comb
    if (!rst_n) AST_RESET_QUIET: assert (!issue); // R1
endmodule

bind bus_req_arbiter bus_req_arbiter_chk chk_i (.*);

// File: tb/bus_req_arbiter_tb_top.sv
module bus_req_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 2;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic req_pend = 0, req_lock = 0, req_lock_last = 0, pa_new = 0, pa_done = 0;
  logic breq_n, prio_n, issue, lock_held, prio_seen;

  int checks = 0, failures = 0;
  bit finished = 0;

  int m_cnt = 0;
  bit m_prio = 0, m_seen = 0, m_lock = 0, m_breq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_req_arbiter #(.CNT_W(CNT_W)) dut_i (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prio = 0; m_seen = 0; m_lock = 0; m_breq = 0;
    end else begin
      automatic bit iss = req_pend && (!m_seen || m_lock);
      automatic int nxt = m_cnt;
      if (pa_new && !pa_done && m_cnt < MAXC) nxt = m_cnt + 1;
      else if (pa_done && !pa_new && m_cnt > 0) nxt = m_cnt - 1;
      m_seen = m_prio;
      m_prio = (nxt != 0) || (m_cnt != 0);
      m_cnt  = nxt;
      m_breq = req_pend;
      if (iss && req_lock) m_lock = !req_lock_last;
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    if (!rst_n) begin
      chk("R1", "breq_n", breq_n, 1'b1);
      chk("R1", "prio_n", prio_n, 1'b1);
      chk("R1", "issue", issue, 1'b0);
      chk("R1", "lock_held", lock_held, 1'b0);
      chk("R1", "prio_seen", prio_seen, 1'b0);
    end else begin
      chk("R2", "breq_n", breq_n, !m_breq);
      chk("R6_R7", "prio_n", prio_n, !m_prio);
      chk("R8", "prio_seen", prio_seen, m_seen);
      chk("R5", "lock_held", lock_held, m_lock);
      chk(m_seen ? (m_lock ? "R5" : "R4") : "R3", "issue", issue,
          req_pend && (!m_seen || m_lock));
    end
  end

  task automatic step(input bit p, input bit l, input bit ll, input bit n, input bit d);
    req_pend = p; req_lock = l; req_lock_last = ll; pa_new = n; pa_done = d;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: requests pass freely with no priority
    step(1,0,0,0,0); step(0,0,0,0,0); step(1,0,0,0,0);
    // R5: start locked sequence, then priority arrives, sequence keeps issuing
    step(1,1,0,0,0);
    step(1,1,0,1,0);  // R7: counter nonzero, prio_n low
    step(1,1,0,0,0);  // R8: first cycle of low prio_n, still passes
    step(1,1,0,0,0);
    step(1,1,1,0,0);  // last of lock
    step(1,0,0,0,0);  // R4: blocked
    step(1,1,0,0,0);  // R4: locked start blocked under priority
    // R6: saturate counter
    step(1,0,0,1,0); step(0,0,0,1,0); step(0,0,0,1,0); step(0,0,0,1,1);
    step(0,0,0,0,1); step(0,0,0,0,1); step(0,0,0,0,1);
    step(1,0,0,0,1);  // ignored at zero
    step(1,0,0,0,0); step(1,0,0,0,0); step(1,0,0,0,0);
    for (int i = 0; i < 3000; i++) begin
      automatic bit p = ($urandom % 3) != 0;
      automatic bit l = ($urandom % 2) == 0;
      automatic bit ll = ($urandom % 4) == 0;
      automatic bit n = ($urandom % 5) == 0;
      automatic bit d = ($urandom % 3) == 0;
      step(p, l, ll, n, d);
      if (i == 1500) begin
        rst_n = 0; step(0,0,0,0,0); step(0,0,0,0,0); rst_n = 1;
      end
    end
    step(0,0,0,0,0);
    @(posedge clk); #2;
    finish_run();
  end
endmodule